// File: doc/BRIEF.md
# Token-Passing Three-Client Arbiter

This block shares one bus among three clients by circulating a single ownership token. Each client has a dedicated controller that raises that client's acknowledge. A small central ring pointer names the controller that should receive the token next. A controller that holds the token and sees its client requesting starts serving. It serves until the request falls. A controller that holds the token with no request pending gives it up at once.

The token moves only through registered hand-off flags. In the cycle after a controller gives up the token, it raises its hand-off flag. The OR of the three flags enables the ring pointer. In that same cycle the pointer presents the index of the next client in fixed cyclic order. That client's controller then takes the token. No combinational priority logic exists, so every grant decision is local to the controller that holds the token.

Clients must hold a request until they are acknowledged. They may keep it high for a bounded number of further cycles, and dropping the request ends the service. Under that rule every request is acknowledged within a bounded time, whatever the pattern of requests.

Top module: `tok_arb`

## Requirements
- R1: After a clock edge with `rst_n` low, `ack` and `pass` are all zero and `sel` reads 3 (no client). Client A's controller holds the token, regardless of `req`.
- R2: At most one bit of `ack` is high in any cycle. Exactly one controller owns the token or is raising its hand-off flag.
- R3: A controller that holds the token and sees its request bit high at a clock edge raises its `ack` bit after that edge. If `req[0]` is high when reset is released, `ack[0]` is high after the first edge.
- R4: While a client is being served, its `ack` bit stays high on every cycle that its `req` bit stays high.
- R5: If a served client's `req` bit is low at an edge, its `ack` bit falls after that edge. Its `pass` bit (bit i for client i) is then high for exactly one cycle.
- R6: A token holder whose request is low at an edge raises its `pass` bit after that edge. With no requests at all, single-cycle `pass` pulses appear on every second cycle, for A, then B, then C.
- R7: `sel` encodes 0 for client A, 1 for B, 2 for C and 3 for none. In a cycle where `pass[i]` is high, `sel` equals (i+1) mod 3. In every other cycle it is 3.
- R8: The token visits clients strictly in the order A, B, C, A. The ring pointer moves only in cycles where some `pass` bit is high.
- R9: At most one bit of `pass` is high in any cycle.
- R10: A client that holds its request for at most 7 cycles past its acknowledge is never kept waiting. If every client follows this rule, each raised request is acknowledged within 40 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 3 | Request per client, bit 0 = A, bit 1 = B, bit 2 = C |
| ack | output | 3 | Acknowledge per client, same bit order |
| sel | output | 2 | Ring selection: 0/1/2 = client A/B/C, 3 = none |
| pass | output | 3 | Registered hand-off flag per controller |

## Verification
The embedded assertions check the following on every cycle:
- the safety properties: mutual exclusion of the acknowledges, a single token, at most one hand-off flag, and agreement between each hand-off flag and the selection it produces;
- the local controller rules: an acknowledge rises only on a request, and the release and hand-off happen one cycle after the request falls.

Some behaviours can only be shown by the bench's scenarios:
- the exact cycle-by-cycle pass order through A, B and C;
- the reset token position;
- the bounded grant latency, which bounded-hold client models stress over thousands of cycles.

// File: rtl/tok_arb_pkg.sv
// Package: shared types and helpers for the token-passing arbiter.
// Assumes client indices run from 0 to n-1 in ring order.
package tok_arb_pkg;

    // Controller ownership states; only CS_SERVE drives an acknowledge.
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_HOLD  = 2'd1,
        CS_SERVE = 2'd2
    } ctrl_state_t;

    // Next index in fixed cyclic order.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 == n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/tok_arb_ctrl.sv
// Per-client controller. It picks up the token when the ring selects it.
// It serves its client while the request is high and hands the token on
// through a registered one-cycle flag.
// Assumes: `selected` is only high in a cycle where another controller hands off.
module tok_arb_ctrl
    import tok_arb_pkg::*;
#(
    parameter bit START_OWNER = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic selected,
    input  logic req,
    output logic ack,
    output logic pass,
    output logic owns
);

    ctrl_state_t state_q, state_d;
    logic        pass_q, pass_d;

    // Next-state and hand-off decision.
    always_comb begin
        state_d = state_q;
        pass_d  = 1'b0;
        unique case (state_q)
            CS_IDLE:  if (selected) state_d = CS_HOLD;
            CS_HOLD: begin
                if (req) begin
                    state_d = CS_SERVE;
                end else begin
                    state_d = CS_IDLE;
                    pass_d  = 1'b1;
                end
            end
            CS_SERVE: begin
                if (!req) begin
                    state_d = CS_IDLE;
                    pass_d  = 1'b1;
                end
            end
            default:  state_d = CS_IDLE;
        endcase
    end

    // State and hand-off flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= START_OWNER ? CS_HOLD : CS_IDLE;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
        end
    end

    assign ack  = (state_q == CS_SERVE);
    assign pass = pass_q;
    assign owns = (state_q != CS_IDLE);

    // R3: an acknowledge only appears on a request seen at the previous edge.
    p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req));

    // R5: a falling request while served releases and hands off next cycle.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> (pass && !ack));

    // R5: the hand-off flag is a single-cycle pulse.
    p_pass_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> !pass);

endmodule

// File: rtl/tok_arb_ring.sv
// Central ring pointer. It tracks the current token owner and advances one
// step whenever a hand-off flag is high. In those cycles it presents the
// next index on `sel`; otherwise `sel` shows the none code N.
// Assumes at most one hand-off flag is high at a time.
module tok_arb_ring #(
    parameter int N     = 3,
    parameter int SEL_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pass,
    output logic [SEL_W-1:0] sel
);

    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_nxt;
    logic             active;

    // Active when any controller hands off.
    assign active  = |pass;
    // Cyclic successor of the current owner.
    assign ptr_nxt = (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    // Selection output: successor while active, else the none code.
    assign sel     = active ? SEL_W'(ptr_nxt) : SEL_W'(N);

    // Pointer register; reset points at client 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (active) ptr_q <= ptr_nxt;
    end

    // R8: the pointer holds still when nobody hands off.
    p_ptr_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(ptr_q));

    // R7: the pointer never leaves the client range.
    p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < PTR_W'(N));

endmodule

// File: rtl/tok_arb.sv
// Top of the token-passing arbiter. It has one controller per client and
// a shared ring pointer. Client 0 owns the token after reset.
// Assumes clients hold each request until acknowledged.
module tok_arb
    import tok_arb_pkg::*;
#(
    parameter int N     = 3,
    parameter int SEL_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     ack,
    output logic [SEL_W-1:0] sel,
    output logic [N-1:0]     pass
);

    logic [N-1:0] owns;

    tok_arb_ring #(.N(N), .SEL_W(SEL_W)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .pass  (pass),
        .sel   (sel)
    );

    // One controller per client; client 0 starts with the token.
    for (genvar i = 0; i < N; i++) begin : g_ctrl
        logic picked;
        assign picked = (sel == SEL_W'(i));

        tok_arb_ctrl #(.START_OWNER(i == 0)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .selected (picked),
            .req      (req[i]),
            .ack      (ack[i]),
            .pass     (pass[i]),
            .owns     (owns[i])
        );

        // R7: a hand-off from client i selects its cyclic successor.
        p_pass_selects_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pass[i] |-> (sel == SEL_W'(ring_next(i, N))));
    end

    // R2: mutual exclusion of acknowledges.
    p_ack_mutex_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    // R2: exactly one token is either owned or in flight.
    p_one_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(owns | pass));

    // R9: at most one hand-off flag at a time.
    p_pass_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pass));

endmodule

// File: tb/tok_arb_test.sv
`timescale 1ns/1ps
module tok_arb_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = 3'b000;
    logic [2:0] ack;
    logic [1:0] sel;
    logic [2:0] pass;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tok_arb uut (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .ack   (ack),
        .sel   (sel),
        .pass  (pass)
    );

    // Vector: {req, expected ack, expected pass, expected sel}, one per edge after reset.
    localparam int NV = 14;
    localparam logic [10:0] VEC [NV] = '{
        {3'b000, 3'b000, 3'b001, 2'd1},  // R6 A idle holder passes
        {3'b000, 3'b000, 3'b000, 2'd3},  // R8 B takes token
        {3'b010, 3'b010, 3'b000, 2'd3},  // R3 B served
        {3'b010, 3'b010, 3'b000, 2'd3},  // R4 held
        {3'b000, 3'b000, 3'b010, 2'd2},  // R5 B releases, selects C
        {3'b000, 3'b000, 3'b000, 2'd3},  // R8 C takes token
        {3'b100, 3'b100, 3'b000, 2'd3},  // R3 C served
        {3'b101, 3'b100, 3'b000, 2'd3},  // R2 A waits
        {3'b001, 3'b000, 3'b100, 2'd0},  // R5 C releases, selects A
        {3'b001, 3'b000, 3'b000, 2'd3},  // R8 A takes token
        {3'b001, 3'b001, 3'b000, 2'd3},  // R3 A served
        {3'b000, 3'b000, 3'b001, 2'd1},  // R5 A releases
        {3'b000, 3'b000, 3'b000, 2'd3},  // R6 B holds
        {3'b000, 3'b000, 3'b010, 2'd2}   // R6 B passes on
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic chk_reset_state(input string tag);
        chk(ack == 3'b000, {tag, " ack"}, ack, 0);
        chk(pass == 3'b000, {tag, " pass"}, pass, 0);
        chk(sel == 2'd3, {tag, " sel"}, sel, 3);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [2:0] rq;
        int         waitc [3];
        int         tail  [3];
        bit         got   [3];

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk_reset_state("R1 initial reset");

        // Vector table walk.
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            req = VEC[k][10:8];
            @(negedge clk);
            chk(ack == VEC[k][7:5], $sformatf("R2/R3/R4 step %0d ack", k), ack, VEC[k][7:5]);
            chk(pass == VEC[k][4:2], $sformatf("R5/R6 step %0d pass", k), pass, VEC[k][4:2]);
            chk(sel == VEC[k][1:0], $sformatf("R7/R8 step %0d sel", k), sel, VEC[k][1:0]);
        end

        // R1: reset mid-run ignores a high request; R3 first grant to A.
        rst_n = 1'b0;
        req   = 3'b001;
        repeat (2) @(negedge clk);
        chk_reset_state("R1 reset with req");
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 3'b001, "R3 first grant", ack, 1);
        @(negedge clk);
        chk(ack == 3'b001, "R4 hold grant", ack, 1);
        req = 3'b000;
        @(negedge clk);
        chk(ack == 3'b000, "R5 release ack", ack, 0);
        chk(pass == 3'b001, "R5 release pass", pass, 1);
        @(negedge clk);
        chk(pass == 3'b000, "R5 single pulse", pass, 0);

        // Stress with bounded-hold clients.
        rst_n = 1'b0;
        req   = 3'b000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rq    = 3'b000;
        for (int i = 0; i < 3; i++) begin
            waitc[i] = 0;
            tail[i]  = 0;
            got[i]   = 1'b0;
        end
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            chk($onehot0(ack), "R2 mutex", ack, 0);
            chk($onehot0(pass), "R9 single pass", pass, 0);
            if (pass == 3'b000)
                chk(sel == 2'd3, "R7 none", sel, 3);
            else if (pass == 3'b001)
                chk(sel == 2'd1, "R7 after A", sel, 1);
            else if (pass == 3'b010)
                chk(sel == 2'd2, "R7 after B", sel, 2);
            else if (pass == 3'b100)
                chk(sel == 2'd0, "R7 after C", sel, 0);
            for (int i = 0; i < 3; i++) begin
                if (rq[i]) begin
                    if (!got[i]) begin
                        if (ack[i]) begin
                            chk(waitc[i] <= 40, "R10 latency", waitc[i], 40);
                            got[i]  = 1'b1;
                            tail[i] = $urandom_range(7, 0);
                        end else begin
                            waitc[i]++;
                            if (waitc[i] == 41)
                                chk(1'b0, "R10 starved", waitc[i], 40);
                        end
                    end else begin
                        chk(ack[i], "R4 held ack", ack[i], 1);
                    end
                    if (got[i]) begin
                        if (tail[i] == 0) begin
                            rq[i]  = 1'b0;
                            got[i] = 1'b0;
                        end else begin
                            tail[i]--;
                        end
                    end
                end else begin
                    chk(!ack[i], "R5 ack after drop", ack[i], 0);
                    if ($urandom_range(3, 0) == 0) begin
                        rq[i]    = 1'b1;
                        waitc[i] = 0;
                    end
                end
            end
            req = rq;
        end

        finish_run();
    end

endmodule